// File: doc/BRIEF.md
# Page Table Walker

This block translates a virtual address into a physical address by walking a multi-level page table held in memory. A request carries the virtual address, the kind of access (fetch, load or store), the current privilege, a flag that swaps in a saved privilege, a flag that blocks supervisor access to user pages, and the page number of the root table. The walker reads one table entry per level over a single-outstanding request/response memory port. It then reports either a physical address or a fault.

One walker serves four run-time schemes. In pass-through mode no memory is touched. The 32-bit scheme uses two levels, 10-bit indices and 4-byte entries. The 39-bit scheme uses three levels, 9-bit indices and 8-byte entries. The 48-bit scheme uses four levels, 9-bit indices and 8-byte entries. A leaf found above the last level maps a superpage. On success the leaf entry is written back with its accessed flag set, and also its dirty flag on a store. The result is held on `paddr` and `fault` while `done` pulses for one cycle. Entry caching and trap delivery belong to the surrounding pipeline.

Top module: `pt_walker`

## Requirements
- R1: With `scheme` = 0 (pass-through), the walk makes no memory read, `fault` is 0 and `paddr` equals `vaddr`, whatever the upper address bits hold.
- R2: For a translating scheme with virtual width V = 12 + levels × index width, address bits 63 down to V−1 must be all zeros or all ones. Otherwise the walk faults with no memory read.
- R3: The scheme codes are 1 for two levels with 10-bit indices and 4-byte entries, 2 for three levels with 9-bit indices and 8-byte entries, and 3 for four levels with 9-bit indices and 8-byte entries. The first table sits at `rootPpn` << 12. Indices are consumed from the most significant one down. Each entry is read at table base + index × entry size, and 4-byte entries are carried on `memRdata[31:0]`.
- R4: An entry with bit 0 (valid) set and bits 1, 2 and 3 (read, write, execute) all clear is a table pointer. The next table base is entry bits from 10 upward, shifted left by 12.
- R5: A table pointer found at the last level makes the walk fault.
- R6: An entry address not below `MEM_LIMIT` makes the walk fault without issuing that read.
- R7: A leaf needs valid set and the bit for the access: execute (bit 3) for fetch (`accKind` 0), read (bit 1) for load (1), write (bit 2) for store (2). Effective user privilege (0) also needs bit 4 (user) set. A failing leaf faults.
- R8: When `userBlock` is set and the effective privilege is supervisor (1), a leaf that a user access would be allowed through faults. At other privileges the flag has no effect.
- R9: When `modPriv` is set, `prevPriv` replaces `privLevel` as the effective privilege.
- R10: After a leaf passes, the walker writes the entry back to the same address with bit 6 set, and also bit 7 on a store. The write uses the scheme's entry width, then `done` follows.
- R11: The physical address is the leaf's page number ORed with the virtual page-number bits below the leaf's level, shifted left by 12 and joined with the 12 offset bits of `vaddr`.
- R12: After reset, `done`, `fault` and `memReq` are 0 and `paddr` is 0. A fault raises `fault` with `paddr` all ones. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken while idle) |
| vaddr | input | 64 | Virtual address |
| accKind | input | 2 | 0 fetch, 1 load, 2 store |
| scheme | input | 2 | 0 pass-through, 1 two-level, 2 three-level, 3 four-level |
| privLevel | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| modPriv | input | 1 | Use `prevPriv` as effective privilege |
| prevPriv | input | 2 | Saved privilege |
| userBlock | input | 1 | Block supervisor access to user pages |
| rootPpn | input | 52 | Page number of the root table |
| memReq | output | 1 | Memory request, one cycle per access |
| memWrite | output | 1 | Request is a write |
| memWide | output | 1 | Entry width is 8 bytes (else 4) |
| memAddr | output | 64 | Entry address |
| memWdata | output | 64 | Write-back entry data |
| memRvalid | input | 1 | Response (read data or write acknowledge) |
| memRdata | input | 64 | Read data |
| done | output | 1 | Walk finished, one-cycle pulse |
| fault | output | 1 | Walk failed |
| paddr | output | 64 | Physical address, all ones on fault |

## Verification
A wrong remaining-level count or base register shows at the ports one walk later, either as an entry read at the wrong address or as a physical address with the wrong superpage bits. The bench compares this against hand-built tables. A permission or privilege mix-up turns a good walk into a fault, or a fault into a result, by the same `done` pulse. The number of reads per walk exposes early or late aborts. A broken write-back shows up in the memory image after the walk ends, before the next walk starts.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {SCH_OFF = 2'd0, SCH_TWO = 2'd1, SCH_THREE = 2'd2, SCH_FOUR = 2'd3} scheme_e;
  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;

  localparam int BIT_VALID = 0;
  localparam int BIT_RD    = 1;
  localparam int BIT_WR    = 2;
  localparam int BIT_EX    = 3;
  localparam int BIT_USER  = 4;
  localparam int BIT_ACC   = 6;
  localparam int BIT_DIRTY = 7;
  localparam int PPN_LSB   = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic bareDone;
    logic faultOut;
    logic capture;
    logic step;
    logic leafOk;
  } ptwCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic isBare;
    logic canonOk;
    logic addrLegal;
    logic isTable;
    logic atLastLevel;
    logic leafDenied;
  } ptwStat_t;

  function automatic logic [2:0] levelsOf(scheme_e s);
    case (s)
      SCH_TWO:   return 3'd2;
      SCH_THREE: return 3'd3;
      SCH_FOUR:  return 3'd4;
      default:   return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] idxWidthOf(scheme_e s);
    return (s == SCH_TWO) ? 4'd10 : 4'd9;
  endfunction
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PG_SHIFT = 12,
  parameter logic [XLEN-1:0] MEM_LIMIT = XLEN'(32'h8000_0000)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ptwCtl_t                  ctl,
  output ptwStat_t                 stat,
  input  logic [XLEN-1:0]          reqVaddr,
  input  logic [1:0]               reqAcc,
  input  logic [1:0]               reqScheme,
  input  logic [1:0]               reqPriv,
  input  logic                     reqModPriv,
  input  logic [1:0]               reqPrevPriv,
  input  logic                     reqUserBlock,
  input  logic [XLEN-PG_SHIFT-1:0] reqRootPpn,
  input  logic [XLEN-1:0]          memRdata,
  output logic [XLEN-1:0]          memAddr,
  output logic [XLEN-1:0]          memWdata,
  output logic                     memWide,
  output logic [XLEN-1:0]          paddr,
  output logic                     fault
);
  scheme_e         schemeReg;
  acc_e            accReg;
  logic [XLEN-1:0] vaReg, baseReg, pteReg, paddrReg;
  logic            supReg, blkReg, faultReg;
  logic [1:0]      levelIdx;

  logic [1:0] effMode;
  assign effMode = reqModPriv ? reqPrevPriv : reqPriv;

  // per-scheme geometry
  logic [2:0] levels;
  logic [3:0] idxW;
  logic       wide;
  logic [6:0] vaBits, levelShift;
  always_comb begin
    levels     = levelsOf(schemeReg);
    idxW       = idxWidthOf(schemeReg);
    wide       = (schemeReg != SCH_TWO);
    vaBits     = 7'(PG_SHIFT) + 7'(levels) * 7'(idxW);
    levelShift = 7'(levelIdx) * 7'(idxW);
  end

  // sign-extension check on the upper address bits
  logic [XLEN-1:0] topPart, topMask;
  always_comb begin
    topPart = vaReg >> (vaBits - 7'd1);
    topMask = {XLEN{1'b1}} >> (vaBits - 7'd1);
  end

  // index and entry address for the current level
  logic [9:0]      idxMask, idx;
  logic [XLEN-1:0] entryAddr;
  always_comb begin
    idxMask   = (idxW == 4'd10) ? 10'h3ff : 10'h1ff;
    idx       = 10'(vaReg >> (7'(PG_SHIFT) + levelShift)) & idxMask;
    entryAddr = baseReg + (XLEN'(idx) << (wide ? 3 : 2));
  end

  // leaf evaluation
  logic needBit, typeOk, userGrant, privOk;
  always_comb begin
    case (accReg)
      ACC_FETCH: needBit = pteReg[BIT_EX];
      ACC_STORE: needBit = pteReg[BIT_WR];
      default:   needBit = pteReg[BIT_RD];
    endcase
    typeOk    = pteReg[BIT_VALID] && needBit;
    userGrant = typeOk && pteReg[BIT_USER];
    privOk    = typeOk && (supReg || pteReg[BIT_USER]);
  end

  // physical address synthesis, superpage bits folded in
  logic [XLEN-1:0] lowMask, pageMask, ppnField, vpnField, leafPa, setBits;
  always_comb begin
    lowMask  = (XLEN'(1) << levelShift) - XLEN'(1);
    pageMask = (XLEN'(1) << PG_SHIFT) - XLEN'(1);
    ppnField = pteReg >> PPN_LSB;
    vpnField = vaReg >> PG_SHIFT;
    leafPa   = ((ppnField | (vpnField & lowMask)) << PG_SHIFT) | (vaReg & pageMask);
    setBits  = '0;
    setBits[BIT_ACC] = 1'b1;
    if (accReg == ACC_STORE) setBits[BIT_DIRTY] = 1'b1;
  end

  always_comb begin
    stat.isBare      = (schemeReg == SCH_OFF);
    stat.canonOk     = (topPart == '0) || (topPart == topMask);
    stat.addrLegal   = (entryAddr < MEM_LIMIT);
    stat.isTable     = pteReg[BIT_VALID] && !pteReg[BIT_RD] && !pteReg[BIT_WR] && !pteReg[BIT_EX];
    stat.atLastLevel = (levelIdx == 2'd0);
    stat.leafDenied  = (blkReg && userGrant) || !privOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      schemeReg <= SCH_OFF;
      accReg    <= ACC_FETCH;
      vaReg     <= '0;
      baseReg   <= '0;
      pteReg    <= '0;
      paddrReg  <= '0;
      supReg    <= 1'b0;
      blkReg    <= 1'b0;
      faultReg  <= 1'b0;
      levelIdx  <= '0;
    end else begin
      if (ctl.accept) begin
        vaReg     <= reqVaddr;
        accReg    <= acc_e'(reqAcc);
        schemeReg <= scheme_e'(reqScheme);
        supReg    <= (effMode != 2'd0);
        blkReg    <= (effMode == 2'd1) && reqUserBlock;
        baseReg   <= XLEN'(reqRootPpn) << PG_SHIFT;
        levelIdx  <= 2'(levelsOf(scheme_e'(reqScheme)) - 3'd1);
        faultReg  <= 1'b0;
        paddrReg  <= '0;
      end
      if (ctl.capture) pteReg <= wide ? memRdata : XLEN'(memRdata[31:0]);
      if (ctl.step) begin
        baseReg  <= (pteReg >> PPN_LSB) << PG_SHIFT;
        levelIdx <= levelIdx - 2'd1;
      end
      if (ctl.bareDone) paddrReg <= vaReg;
      if (ctl.leafOk)   paddrReg <= leafPa;
      if (ctl.faultOut) begin
        faultReg <= 1'b1;
        paddrReg <= '1;
      end
    end
  end

  assign memAddr  = entryAddr;
  assign memWdata = pteReg | setBits;
  assign memWide  = wide;
  assign paddr    = paddrReg;
  assign fault    = faultReg;

  assert_offset_kept_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.leafOk |=> paddr[PG_SHIFT-1:0] == $past(vaReg[PG_SHIFT-1:0]));
  assert_fault_ones_R12: assert property (@(posedge clk) disable iff (!rstN)
    ctl.faultOut |=> (fault && paddr == '1));
  assert_no_step_past_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> !stat.atLastLevel);
endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  ptwStat_t stat,
  input  logic     memRvalid,
  output ptwCtl_t  ctl,
  output logic     memReq,
  output logic     memWrite,
  output logic     done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_READ, ST_WAITR, ST_EVAL, ST_WRITE, ST_WAITW, ST_DONE
  } state_e;

  state_e state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    done      = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        ctl.accept = 1'b1;
        nextState  = ST_START;
      end
      ST_START: begin
        if (stat.isBare) begin
          ctl.bareDone = 1'b1;
          nextState    = ST_DONE;
        end else if (!stat.canonOk) begin
          ctl.faultOut = 1'b1;
          nextState    = ST_DONE;
        end else begin
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        if (!stat.addrLegal) begin
          ctl.faultOut = 1'b1;
          nextState    = ST_DONE;
        end else begin
          memReq    = 1'b1;
          nextState = ST_WAITR;
        end
      end
      ST_WAITR: if (memRvalid) begin
        ctl.capture = 1'b1;
        nextState   = ST_EVAL;
      end
      ST_EVAL: begin
        if (stat.isTable) begin
          if (stat.atLastLevel) begin
            ctl.faultOut = 1'b1;
            nextState    = ST_DONE;
          end else begin
            ctl.step  = 1'b1;
            nextState = ST_READ;
          end
        end else if (stat.leafDenied) begin
          ctl.faultOut = 1'b1;
          nextState    = ST_DONE;
        end else begin
          ctl.leafOk = 1'b1;
          nextState  = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq    = 1'b1;
        memWrite  = 1'b1;
        nextState = ST_WAITW;
      end
      ST_WAITW: if (memRvalid) nextState = ST_DONE;
      default: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  assert_read_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite) |-> stat.addrLegal);
  assert_write_only_granted_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> !stat.leafDenied);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PG_SHIFT = 12,
  parameter logic [XLEN-1:0] MEM_LIMIT = XLEN'(32'h8000_0000)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [XLEN-1:0]          vaddr,
  input  logic [1:0]               accKind,
  input  logic [1:0]               scheme,
  input  logic [1:0]               privLevel,
  input  logic                     modPriv,
  input  logic [1:0]               prevPriv,
  input  logic                     userBlock,
  input  logic [XLEN-PG_SHIFT-1:0] rootPpn,
  output logic                     memReq,
  output logic                     memWrite,
  output logic                     memWide,
  output logic [XLEN-1:0]          memAddr,
  output logic [XLEN-1:0]          memWdata,
  input  logic                     memRvalid,
  input  logic [XLEN-1:0]          memRdata,
  output logic                     done,
  output logic                     fault,
  output logic [XLEN-1:0]          paddr
);
  ptwCtl_t  ctl;
  ptwStat_t stat;

  ptw_control u_control (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .memRvalid(memRvalid),
    .ctl(ctl), .memReq(memReq), .memWrite(memWrite), .done(done)
  );

  ptw_datapath #(.XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .MEM_LIMIT(MEM_LIMIT)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat),
    .reqVaddr(vaddr), .reqAcc(accKind), .reqScheme(scheme), .reqPriv(privLevel),
    .reqModPriv(modPriv), .reqPrevPriv(prevPriv), .reqUserBlock(userBlock),
    .reqRootPpn(rootPpn), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memWide(memWide), .paddr(paddr), .fault(fault)
  );
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, start, modPriv, userBlock;
  logic [63:0] vaddr;
  logic [1:0]  accKind, scheme, privLevel, prevPriv;
  logic [51:0] rootPpn;
  logic        memReq, memWrite, memWide, memRvalid, done, fault;
  logic [63:0] memAddr, memWdata, memRdata, paddr;

  pt_walker #(.MEM_LIMIT(64'h8000)) u_pt_walker (
    .clk(clk), .rstN(rstN), .start(start), .vaddr(vaddr), .accKind(accKind),
    .scheme(scheme), .privLevel(privLevel), .modPriv(modPriv), .prevPriv(prevPriv),
    .userBlock(userBlock), .rootPpn(rootPpn), .memReq(memReq), .memWrite(memWrite),
    .memWide(memWide), .memAddr(memAddr), .memWdata(memWdata), .memRvalid(memRvalid),
    .memRdata(memRdata), .done(done), .fault(fault), .paddr(paddr)
  );

  // memory model: 32 KB, response one cycle after request
  logic [63:0] mem [0:4095];
  int readTotal = 0;
  always @(posedge clk) begin
    memRvalid <= memReq;
    if (memReq) begin
      if (memWrite) begin
        if (memWide) mem[memAddr[14:3]] <= memWdata;
        else if (memAddr[2]) mem[memAddr[14:3]][63:32] <= memWdata[31:0];
        else mem[memAddr[14:3]][31:0] <= memWdata[31:0];
      end else begin
        readTotal = readTotal + 1;
        if (memWide) memRdata <= mem[memAddr[14:3]];
        else memRdata <= {32'h0, memAddr[2] ? mem[memAddr[14:3]][63:32] : mem[memAddr[14:3]][31:0]};
      end
    end
  end

  int compared = 0;
  int mismatched = 0;
  logic        gotFault;
  logic [63:0] gotPa;
  int          gotReads;
  logic        gotPulseOk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runWalk(input logic [1:0] sch, input logic [63:0] va, input logic [1:0] acc,
                         input logic [1:0] pr, input logic mp, input logic [1:0] pp,
                         input logic ub, input logic [19:0] root);
    int startReads;
    int waitCount;
    @(negedge clk);
    scheme = sch; vaddr = va; accKind = acc; privLevel = pr; modPriv = mp;
    prevPriv = pp; userBlock = ub; rootPpn = 52'(root); start = 1'b1;
    startReads = readTotal;
    @(negedge clk);
    start = 1'b0;
    waitCount = 0;
    while (!done && waitCount < 500) begin
      @(negedge clk);
      waitCount++;
    end
    gotFault = fault;
    gotPa    = paddr;
    gotReads = readTotal - startReads;
    @(negedge clk);
    gotPulseOk = !done && (waitCount < 500);
  endtask

  typedef struct packed {
    logic [1:0]  sch;
    logic [63:0] va;
    logic [1:0]  acc;
    logic [1:0]  pr;
    logic        mp;
    logic [1:0]  pp;
    logic        ub;
    logic [19:0] root;
    logic        expF;
    logic [63:0] expPa;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{2'd2, 64'h403123, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 20'd1, 1'b0, 64'h12345123},        // R3 R4 three-level load
    '{2'd2, 64'h403123, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 20'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF}, // R7 user on non-user page
    '{2'd2, 64'h403123, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 20'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF}, // R7 fetch without execute
    '{2'd2, 64'hA07456, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 20'd1, 1'b0, 64'h40007456},        // R11 superpage fetch
    '{2'd2, 64'hA07456, 2'd1, 2'd1, 1'b0, 2'd0, 1'b1, 20'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF}, // R8 blocked
    '{2'd2, 64'hA07456, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 20'd1, 1'b0, 64'h40007456},        // R8 unblocked
    '{2'd2, 64'hA07456, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 20'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF}, // R7 store no write
    '{2'd1, 64'h801ABC, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 20'd4, 1'b0, 64'hABCDEABC},        // R3 two-level
    '{2'd1, 64'hC05DEF, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 20'd4, 1'b0, 64'h405DEF},          // R11 two-level superpage
    '{2'd3, 64'h403123, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 20'd7, 1'b0, 64'h12345123},        // R3 four-level
    '{2'd2, 64'h403123, 2'd1, 2'd3, 1'b1, 2'd0, 1'b0, 20'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF}, // R9 saved user
    '{2'd2, 64'hA07456, 2'd1, 2'd3, 1'b1, 2'd1, 1'b1, 20'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF}, // R9 saved supervisor blocked
    '{2'd2, 64'hA07456, 2'd1, 2'd3, 1'b0, 2'd0, 1'b1, 20'd1, 1'b0, 64'h40007456},        // R8 machine unaffected
    '{2'd2, 64'h404000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 20'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF}  // R5 out of levels
  };

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 64'h0;
    mem[12'h200] = 64'h801;                          // three-level root[0] -> page 2
    mem[12'h402] = 64'hC01;                          // level-1 idx 2 -> page 3
    mem[12'h405] = 64'h1000001B;                     // level-1 idx 5 superpage leaf
    mem[12'h406] = 64'h40001;                        // level-1 idx 6 -> page 0x100
    mem[12'h603] = 64'h48D1407;                      // leaf page 0x12345, V R W
    mem[12'h604] = 64'h1401;                         // pointer at last level
    mem[12'h801] = {32'h00100013, 32'h00001801};     // two-level root idx 3 leaf, idx 2 -> page 6
    mem[12'hC00] = {32'h2AF3781F, 32'h00000000};     // two-level leaf at 0x6004
    mem[12'hE00] = 64'h401;                          // four-level root[0] -> page 1

    rstN = 1'b0; start = 1'b0; vaddr = '0; accKind = '0; scheme = '0; privLevel = '0;
    modPriv = 1'b0; prevPriv = '0; userBlock = 1'b0; rootPpn = '0;
    repeat (3) @(negedge clk);
    check("R12 reset done", 64'(done), 64'h0);
    check("R12 reset fault", 64'(fault), 64'h0);
    check("R12 reset memReq", 64'(memReq), 64'h0);
    check("R12 reset paddr", paddr, 64'h0);
    rstN = 1'b1;

    for (int v = 0; v < 14; v++) begin
      runWalk(VECS[v].sch, VECS[v].va, VECS[v].acc, VECS[v].pr, VECS[v].mp,
              VECS[v].pp, VECS[v].ub, VECS[v].root);
      check($sformatf("R3 R7 R12 vec %0d fault", v), 64'(gotFault), 64'(VECS[v].expF));
      check($sformatf("R11 R12 vec %0d paddr", v), gotPa, VECS[v].expPa);
    end

    // R10 write-back state after the table
    check("R10 loads set accessed only", mem[12'h603], 64'h48D1447);
    check("R10 narrow write upper half", mem[12'hC00], {32'h2AF3785F, 32'h0});
    check("R10 narrow write superpage", mem[12'h801], {32'h00100053, 32'h00001801});
    runWalk(2'd2, 64'h403123, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 20'd1);
    check("R10 store result", gotPa, 64'h12345123);
    @(negedge clk);
    check("R10 store sets dirty", mem[12'h603], 64'h48D14C7);
    check("R12 done pulse", 64'(gotPulseOk), 64'h1);

    // R1 pass-through
    runWalk(2'd0, 64'hDEADBEEF00001234, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 20'd1);
    check("R1 bare paddr", gotPa, 64'hDEADBEEF00001234);
    check("R1 bare fault", 64'(gotFault), 64'h0);
    check("R1 bare reads", 64'(gotReads), 64'h0);

    // R2 sign-extension checks
    runWalk(2'd2, 64'h0000004000000000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 20'd1);
    check("R2 three-level noncanonical fault", 64'(gotFault), 64'h1);
    check("R2 three-level noncanonical reads", 64'(gotReads), 64'h0);
    runWalk(2'd1, 64'h80000000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 20'd4);
    check("R2 two-level noncanonical fault", 64'(gotFault), 64'h1);
    check("R2 two-level noncanonical reads", 64'(gotReads), 64'h0);
    runWalk(2'd2, 64'hFFFFFFC000000000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 20'd1);
    check("R2 negative canonical walks", 64'(gotReads), 64'h1);
    check("R7 invalid entry faults", gotPa, 64'hFFFFFFFFFFFFFFFF);

    // R6 illegal entry address
    runWalk(2'd2, 64'hC00000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 20'd1);
    check("R6 illegal address fault", 64'(gotFault), 64'h1);
    check("R6 illegal address reads", 64'(gotReads), 64'h2);

    // R5 read count when levels run out
    runWalk(2'd2, 64'h404000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 20'd1);
    check("R5 last-level pointer reads", 64'(gotReads), 64'h3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule